// File: doc/BRIEF.md
# Atomic Lock Operation Classifier

This block observes the stream of memory operations retired by several hardware threads and decides, operation by operation, whether each one acquires a mutex lock, fails to acquire one, or releases one. The instruction set has no explicit acquire or release instructions. The block infers them from three things: the opcode class that retired, the value it read and wrote, and the owner it remembers for the address.

A small associative table holds the lock addresses. Each entry has a valid bit, the address, a held flag and the owning thread. An atomic operation on an address that is not in the table allocates an entry for it. Plain stores never allocate an entry. They are still compared with every tracked address, so that a store from the owner is seen as a release. At most one operation is accepted per cycle, and the block handles operations strictly in the order they arrive.

The block emits one registered event per accepted operation. The event carries a code, the address, the thread, and a flag that separates a thread contending with itself from contention between threads. Downstream logic can use these events to park and wake threads.

Top module: `lockop_classifier`

## Requirements
- R1: Every cycle with `in_valid` high yields `ev_valid` high in the next cycle, with `ev_addr` and `ev_tid` equal to that operation's address and thread. A cycle without `in_valid` yields `ev_valid` low in the next cycle.
- R2: A test-and-set (kind 0) that reads zero and writes non-zero gives event code 1 (acquire), unless another thread holds the address. The issuing thread then becomes the owner.
- R3: A test-and-set that reads non-zero and writes non-zero gives code 2 (failed acquire / contention).
- R4: A compare-and-swap (kind 1) or swap (kind 2) that writes a value different from the one it read gives code 1, unless another thread holds the address. One that writes back the value it read gives code 2.
- R5: A plain store (kind 3) from the owner of a held tracked address gives code 3 (release) and frees the lock. Any other store gives code 0 (none) and changes nothing.
- R6: An atomic operation that writes zero from the owner of a held address gives code 3 and frees the lock. This check takes priority over the value rules.
- R7: `ev_self` is 1 only on a code 2 event where the failing thread already owns the address. It is 0 for contention between threads.
- R8: An atomic operation that succeeds by its values on an address held by a different thread gives code 2. The owner is kept.
- R9: An atomic operation on an untracked address allocates an entry. A store to an untracked address gives code 0 and allocates nothing.
- R10: The table holds NUM_ENTRIES addresses. Free entries fill from the lowest index. When the table is full, entries are replaced in round-robin order starting at index 0, and a replaced address becomes untracked.
- R11: Reset empties the table and leaves `ev_valid` low until the first accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A retired operation is present this cycle |
| in_tid | input | TID_W | Issuing thread |
| in_addr | input | ADDR_W | Physical address |
| in_kind | input | 2 | 0 test-and-set, 1 compare-and-swap, 2 swap, 3 plain store |
| in_old | input | DATA_W | Value read from memory |
| in_new | input | DATA_W | Value written to memory |
| ev_valid | output | 1 | Event present |
| ev_code | output | 2 | 0 none, 1 acquire, 2 failed acquire, 3 release |
| ev_self | output | 1 | Failed acquire by the current owner |
| ev_addr | output | ADDR_W | Address of the classified operation |
| ev_tid | output | TID_W | Thread of the classified operation |

## Verification
The assertions check, on every cycle, the behaviours that depend only on the current operation: the one-cycle event timing and echo of address and thread, the fixed failure outcome of a non-zero test-and-set or a same-value swap, stores never producing acquire or fail codes, the self-contention flag appearing only with a failure, and quiet output after reset. Behaviours that depend on table state can only be shown by the bench's operation sequences. These are ownership, release by the owner alone, contention against another holder, allocation on atomics but not stores, and round-robin replacement once the table is full.

// File: rtl/lockop_pkg.sv
package lockop_pkg;
  typedef enum logic [1:0] {
    OP_TAS   = 2'd0,
    OP_CAS   = 2'd1,
    OP_SWAP  = 2'd2,
    OP_STORE = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_ACQ  = 2'd1,
    EV_FAIL = 2'd2,
    EV_REL  = 2'd3
  } ev_code_e;
endpackage

// File: rtl/lockop_cam.sv
// Associative lookup of one address against every valid table entry.
module lockop_cam #(
  parameter int N      = 8,
  parameter int ADDR_W = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]             tab_valid,
  input  logic [N-1:0][ADDR_W-1:0] tab_addr,
  input  logic [ADDR_W-1:0]        key,
  output logic                     hit,
  output logic [IDX_W-1:0]         hit_idx
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = tab_valid[g] && (tab_addr[g] == key);
  end

  assign hit = |match;

  // Lowest matching index; addresses are unique so at most one matches.
  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/lockop_victim.sv
// Chooses the slot for a new address: lowest free entry, else round-robin.
module lockop_victim #(
  parameter int N      = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     tab_valid,
  input  logic             advance,
  output logic [IDX_W-1:0] pick,
  output logic             full
);
  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;

  assign full = &tab_valid;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!tab_valid[i]) free_idx = IDX_W'(i);
    end
    pick = full ? rr_ptr : free_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (advance) begin
      rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/lockop_decide.sv
// Pure classification of one operation against the state of its entry.
module lockop_decide
  import lockop_pkg::*;
#(
  parameter int TID_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic [1:0]        kind,
  input  logic [TID_W-1:0]  tid,
  input  logic [DATA_W-1:0] rd_val,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              held,
  input  logic [TID_W-1:0]  owner,
  output logic [1:0]        code,
  output logic              self_hit,
  output logic              take,
  output logic              drop
);
  logic mine;
  logic succ;
  logic fail;

  assign mine = held && (owner == tid);

  always_comb begin
    code     = EV_NONE;
    self_hit = 1'b0;
    take     = 1'b0;
    drop     = 1'b0;
    succ     = 1'b0;
    fail     = 1'b0;
    if (kind == OP_STORE) begin
      if (mine) begin
        code = EV_REL;
        drop = 1'b1;
      end
    end else if (mine && (wr_val == '0)) begin
      code = EV_REL;
      drop = 1'b1;
    end else begin
      if (kind == OP_TAS) begin
        succ = (rd_val == '0) && (wr_val != '0);
        fail = (rd_val != '0) && (wr_val != '0);
      end else begin
        succ = (wr_val != rd_val);
        fail = (wr_val == rd_val);
      end
      if (succ) begin
        if (held && !mine) begin
          code = EV_FAIL;
        end else begin
          code = EV_ACQ;
          take = 1'b1;
        end
      end else if (fail) begin
        code     = EV_FAIL;
        self_hit = mine;
      end
    end
  end
endmodule

// File: rtl/lockop_classifier.sv
module lockop_classifier
  import lockop_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int TID_W       = 2,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [TID_W-1:0]  in_tid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_kind,
  input  logic [DATA_W-1:0] in_old,
  input  logic [DATA_W-1:0] in_new,
  output logic              ev_valid,
  output logic [1:0]        ev_code,
  output logic              ev_self,
  output logic [ADDR_W-1:0] ev_addr,
  output logic [TID_W-1:0]  ev_tid
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [NUM_ENTRIES-1:0]             tab_valid;
  logic [NUM_ENTRIES-1:0]             tab_held;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] tab_addr;
  logic [NUM_ENTRIES-1:0][TID_W-1:0]  tab_owner;

  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] pick;
  logic             full;
  logic             alloc;
  logic [IDX_W-1:0] slot;
  logic             cur_held;
  logic [1:0]       code;
  logic             self_hit;
  logic             take;
  logic             drop;

  lockop_cam #(.N(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_cam (
    .tab_valid(tab_valid),
    .tab_addr (tab_addr),
    .key      (in_addr),
    .hit      (hit),
    .hit_idx  (hit_idx)
  );

  // Atomics on an untracked address claim a slot; stores never do.
  assign alloc = in_valid && (in_kind != OP_STORE) && !hit;

  lockop_victim #(.N(NUM_ENTRIES)) u_victim (
    .clk      (clk),
    .rst      (rst),
    .tab_valid(tab_valid),
    .advance  (alloc && full),
    .pick     (pick),
    .full     (full)
  );

  assign slot     = hit ? hit_idx : pick;
  assign cur_held = hit && tab_held[hit_idx];

  lockop_decide #(.TID_W(TID_W), .DATA_W(DATA_W)) u_decide (
    .kind    (in_kind),
    .tid     (in_tid),
    .rd_val  (in_old),
    .wr_val  (in_new),
    .held    (cur_held),
    .owner   (tab_owner[hit_idx]),
    .code    (code),
    .self_hit(self_hit),
    .take    (take),
    .drop    (drop)
  );

  // Table state
  always_ff @(posedge clk) begin
    if (rst) begin
      tab_valid <= '0;
      tab_held  <= '0;
    end else if (in_valid) begin
      if (alloc) begin
        tab_valid[slot] <= 1'b1;
        tab_held[slot]  <= 1'b0;
      end
      if (take) begin
        tab_held[slot] <= 1'b1;
      end else if (drop) begin
        tab_held[slot] <= 1'b0;
      end
    end
  end

  // Address and owner fields carry no reset, like a RAM payload.
  always_ff @(posedge clk) begin
    if (alloc) tab_addr[slot] <= in_addr;
    if (in_valid && take) tab_owner[slot] <= in_tid;
  end

  // Registered event
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_valid <= 1'b0;
      ev_code  <= EV_NONE;
      ev_self  <= 1'b0;
      ev_addr  <= '0;
      ev_tid   <= '0;
    end else begin
      ev_valid <= in_valid;
      if (in_valid) begin
        ev_code <= code;
        ev_self <= self_hit;
        ev_addr <= in_addr;
        ev_tid  <= in_tid;
      end
    end
  end
endmodule

// File: rtl/lockop_classifier_chk.sv
module lockop_classifier_chk #(
  parameter int TID_W  = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [TID_W-1:0]  in_tid,
  input logic [ADDR_W-1:0] in_addr,
  input logic [1:0]        in_kind,
  input logic [DATA_W-1:0] in_old,
  input logic [DATA_W-1:0] in_new,
  input logic              ev_valid,
  input logic [1:0]        ev_code,
  input logic              ev_self,
  input logic [ADDR_W-1:0] ev_addr,
  input logic [TID_W-1:0]  ev_tid
);
  p_event_follows_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ev_valid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !ev_valid);

  p_echo_fields_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (ev_addr == $past(in_addr)) && (ev_tid == $past(in_tid)));

  p_busy_tas_fails_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 2'd0 && in_old != '0 && in_new != '0) |=> ev_code == 2'd2);

  p_same_value_fails_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_kind == 2'd1 || in_kind == 2'd2) && in_new == in_old && in_new != '0)
      |=> ev_code == 2'd2);

  p_store_codes_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 2'd3) |=> (ev_code == 2'd0 || ev_code == 2'd3));

  p_self_only_fail_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_self) |-> ev_code == 2'd2);

  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> !ev_valid);
endmodule

bind lockop_classifier lockop_classifier_chk #(
  .TID_W(TID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/lockop_classifier_test.sv
module lockop_classifier_test;
  localparam int N      = 8;
  localparam int TID_W  = 2;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [TID_W-1:0]  in_tid = '0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [1:0]        in_kind = '0;
  logic [DATA_W-1:0] in_old = '0;
  logic [DATA_W-1:0] in_new = '0;
  logic              ev_valid;
  logic [1:0]        ev_code;
  logic              ev_self;
  logic [ADDR_W-1:0] ev_addr;
  logic [TID_W-1:0]  ev_tid;

  int checks = 0;
  int fails  = 0;

  // Bench-side view of the table, kept from the requirements
  logic              m_valid [N];
  logic              m_held  [N];
  logic [ADDR_W-1:0] m_addr  [N];
  int                m_owner [N];
  int                m_rr;
  string             force_tag = "";

  always #2 clk = ~clk;

  lockop_classifier #(.NUM_ENTRIES(N), .TID_W(TID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tid(in_tid), .in_addr(in_addr),
    .in_kind(in_kind), .in_old(in_old), .in_new(in_new), .ev_valid(ev_valid),
    .ev_code(ev_code), .ev_self(ev_self), .ev_addr(ev_addr), .ev_tid(ev_tid)
  );

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b0;
      m_held[i]  = 1'b0;
      m_owner[i] = 0;
    end
    m_rr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    check(ev_valid == 1'b0, "R11", ev_valid, 0);
  endtask

  task automatic op(input int k, input int t, input int a, input int o, input int n);
    int    idx;
    bit    hit;
    bit    mine;
    bit    succ;
    bit    fl;
    int    ecode;
    bit    eself;
    string tag;
    idx = 0;
    hit = 0;
    for (int i = 0; i < N; i++) begin
      if (m_valid[i] && m_addr[i] == ADDR_W'(a)) begin
        hit = 1;
        idx = i;
      end
    end
    ecode = 0;
    eself = 0;
    if (k == 3) begin
      tag = "R5";
      if (hit && m_held[idx] && m_owner[idx] == t) begin
        ecode = 3;
        m_held[idx] = 0;
      end
    end else begin
      if (!hit) begin
        idx = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) idx = i;
        if (idx < 0) begin
          idx = m_rr;
          m_rr = (m_rr + 1) % N;
        end
        m_valid[idx] = 1;
        m_addr[idx]  = ADDR_W'(a);
        m_held[idx]  = 0;
      end
      mine = m_held[idx] && m_owner[idx] == t;
      if (mine && n == 0) begin
        ecode = 3;
        m_held[idx] = 0;
        tag = "R6";
      end else begin
        if (k == 0) begin
          succ = (o == 0) && (n != 0);
          fl   = (o != 0) && (n != 0);
        end else begin
          succ = (n != o);
          fl   = (n == o);
        end
        if (succ && m_held[idx] && !mine) begin
          ecode = 2;
          tag = "R8";
        end else if (succ) begin
          ecode = 1;
          m_held[idx] = 1;
          m_owner[idx] = t;
          tag = (k == 0) ? "R2" : "R4";
        end else if (fl) begin
          ecode = 2;
          eself = mine;
          tag = (k == 0) ? "R3" : "R4";
        end else begin
          tag = "R9";
        end
      end
    end
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    check(ev_valid == 1'b0, "R1", ev_valid, 0);
    in_valid = 1'b1;
    in_kind  = 2'(k);
    in_tid   = TID_W'(t);
    in_addr  = ADDR_W'(a);
    in_old   = DATA_W'(o);
    in_new   = DATA_W'(n);
    @(negedge clk);
    in_valid = 1'b0;
    check(ev_valid == 1'b1, "R1", ev_valid, 1);
    check(ev_code == 2'(ecode), tag, ev_code, ecode);
    check(ev_self == eself, "R7", ev_self, eself);
    check(ev_addr == ADDR_W'(a) && ev_tid == TID_W'(t), "R1", ev_addr, a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    check(ev_code == 2'd0, "R11", ev_code, 0);

    // Directed ownership and contention
    op(0, 1, 'h10, 'h00, 'hFF);  // R2 acquire
    op(0, 2, 'h10, 'hFF, 'hFF);  // R3 fail, other thread
    op(0, 1, 'h10, 'hFF, 'hFF);  // R7 owner contends with itself
    op(1, 2, 'h10, 'h01, 'h02);  // R8 value success, held by thread 1
    op(3, 2, 'h10, 'hFF, 'h00);  // R5 non-owner store: none
    op(3, 1, 'h10, 'hFF, 'h00);  // R5 owner store: release
    op(0, 2, 'h10, 'h00, 'hFF);  // R2 freed lock now taken by thread 2
    force_tag = "R9";
    op(3, 0, 'h20, 'h00, 'h05);  // untracked store: none, no allocation
    force_tag = "";
    op(1, 0, 'h20, 'h00, 'h01);  // R4 CAS acquire, allocates
    op(2, 0, 'h20, 'h01, 'h00);  // R6 swap writing zero releases
    op(2, 3, 'h30, 'h05, 'h05);  // R4 swap same value fails
    op(2, 3, 'h30, 'h00, 'h07);  // R4 swap acquire

    // Replacement: fill, then evict round-robin
    do_reset();
    for (int i = 0; i < N; i++) op(0, 0, 'h100 + i, 0, 'hFF);
    op(0, 1, 'h200, 0, 'hFF);            // replaces index 0
    force_tag = "R10";
    op(3, 0, 'h100, 0, 0);               // evicted: none
    op(3, 0, 'h101, 0, 0);               // still tracked: release
    force_tag = "";
    op(0, 2, 'h201, 0, 'hFF);            // replaces index 1
    op(0, 2, 'h202, 0, 'hFF);            // replaces index 2
    force_tag = "R10";
    op(3, 0, 'h102, 0, 0);               // evicted: none
    op(3, 0, 'h103, 0, 0);               // index 3 kept: release
    force_tag = "";

    // Reset empties the table
    op(0, 1, 'h300, 0, 'hFF);
    do_reset();
    force_tag = "R11";
    op(3, 1, 'h300, 0, 0);
    force_tag = "";

    // Sweep over kinds, threads and value patterns across more addresses than entries
    begin
      int seq = 0;
      int vals[3] = '{0, 1, 'hFF};
      for (int k = 0; k < 4; k++)
        for (int t = 0; t < 4; t++)
          for (int oi = 0; oi < 3; oi++)
            for (int ni = 0; ni < 3; ni++) begin
              op(k, t, 'h400 + (seq % 10) * 4, vals[oi], vals[ni]);
              seq++;
            end
      for (int r = 0; r < 60; r++) begin
        op((r * 7) % 4, (r * 3) % 4, 'h400 + (r % 5) * 4, vals[r % 3], vals[(r / 3) % 3]);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule